// File: doc/BRIEF.md
# Filter-chip SPI register access engine

This block is an SPI master for one external programmable filter device. It runs single register writes and register reads, all in one 32-bit frame shape. The user side offers a request: read or write, a register address and 24 bits of write data. The engine answers with a one-cycle completion pulse, an error flag and the 24-bit value read back. On the device side it drives an active-low select, a serial clock and a serial data output, and it samples the device's serial data input.

Every frame sends the 24 data bits first and then a trailing byte. That byte holds the register number above a fixed three-bit device tag. A read takes two frames. The first is a write to register 0 whose data is the register number to fetch. The second sends all zeros while the device shifts the answer back. The device keeps driving its data line even when it is not selected, so the engine only listens during that second frame. The two kinds of frame use opposite clock phases for sampling. The serial clock runs at the system clock divided by `DIV`. A select-high pause of `GAP_SCLK` serial clock periods follows every frame.

Top module: `fltspi_engine`

## Requirements
- R1: A frame is 32 bits, sent MSB first. Bits 31..8 carry the 24 data bits. Bits 7..3 carry the register address. Bits 2..0 carry the device tag 3'b101.
- R2: The serial clock is low whenever select is high. Inside a frame it has a period of `DIV` system clocks, and each bit starts with the low half.
- R3: In a write frame, serial data changes only on falling clock edges or at the start of a frame. This keeps it stable on each rising edge, where the device captures it.
- R4: A read of register N sends a write frame to register 0 carrying N as its data. It then sends a second frame whose serial output is all zeros.
- R5: In the read-back frame the input is sampled on each falling clock edge. `rd_data` is the first 24 received bits, with the first bit received as the MSB.
- R6: A read is good only if bits 2..0 of the last received byte equal 3'b101. Otherwise `err` is 1 and `rd_data` is 0.
- R7: The input line is ignored outside read-back frames. A write operation ends with `err` = 0 and `rd_data` unchanged.
- R8: Select is low for exactly one whole frame of 32 rising clock edges, and high between frames.
- R9: Before each frame starts, select has been high for at least `GAP_SCLK*DIV` system clocks. This holds between the two frames of a read and after every frame.
- R10: A request is taken only while `ready` is high, and selection goes low on the next cycle. A request raised while busy is ignored and sends no frame.
- R11: `done` is a single-cycle pulse at the end of the whole operation, and `ready` is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while ready |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | AW | Register address (AW up to 5) |
| req_wdata | input | 24 | Write data |
| ready | output | 1 | Engine idle, request may be given |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Read-back tag mismatch |
| rd_data | output | 24 | Last read value, 0 after an error |
| spi_sel_n | output | 1 | Active-low device select |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
Three situations are hard to reach from the ports. The first is a read-back frame whose trailing tag is wrong. The second is an input line that is busy while no read-back frame runs. The third is a request that arrives while the engine is busy. The bench's device model answers reads from the registers it has been written. A switch makes it return a bad tag on one read, which drives the error path. Outside its own answers the input line carries pseudo-random noise, so any sampling outside the read-back frame would corrupt the held `rd_data`. A second request is raised in the middle of a write, and the frame count at the device shows whether it was dropped.

// File: rtl/fltspi_pkg.sv
package fltspi_pkg;

  localparam int FRAME_W = 32;
  localparam int DATA_W  = 24;
  localparam logic [2:0] CHIP_TAG = 3'b101;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_GAP
  } seq_state_t;

  // Outgoing word: payload first, then register select above the tag.
  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [DATA_W-1:0] data,
    input logic [4:0]        reg_sel
  );
    return {data, reg_sel, CHIP_TAG};
  endfunction

  function automatic logic tag_ok(input logic [7:0] last_byte);
    return last_byte[2:0] == CHIP_TAG;
  endfunction

endpackage

// File: rtl/fltspi_sclk_gen.sv
module fltspi_sclk_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);

  localparam int LO = DIV / 2;
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] sub;

  assign rise_tick = run && (sub == CW'(LO - 1));
  assign fall_tick = run && (sub == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      sub  <= '0;
      sclk <= 1'b0;
    end else begin
      if (fall_tick) sub <= '0;
      else           sub <= sub + 1'b1;
      if (rise_tick)      sclk <= 1'b1;
      else if (fall_tick) sclk <= 1'b0;
    end
  end

endmodule

// File: rtl/fltspi_shreg.sv
module fltspi_shreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word <= '0;
    else if (load)   word <= load_val;
    else if (shift)  word <= {word[W-2:0], din};
  end

endmodule

// File: rtl/fltspi_engine.sv
module fltspi_engine
  import fltspi_pkg::*;
#(
  parameter int DIV      = 8,
  parameter int GAP_SCLK = 2,
  parameter int AW       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data,
  output logic              spi_sel_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int GAP_CYC = GAP_SCLK * DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);
  localparam int BW      = $clog2(FRAME_W);

  seq_state_t          state;
  logic                rd_op;
  logic                rb_phase;
  logic [BW-1:0]       bit_cnt;
  logic [GW-1:0]       gap_cnt;
  logic                rise_tick, fall_tick;
  logic [FRAME_W-1:0]  sr;
  logic [FRAME_W-1:0]  load_val;
  logic [FRAME_W-1:0]  first_frame;
  logic [FRAME_W-1:0]  rx_word;
  logic [4:0]          addr5;

  // Named internal events, also observed by the checker.
  logic accept, xfer, frame_end, gap_end, rb_start, op_end, rb_frame, load;

  assign ready     = (state == ST_IDLE);
  assign xfer      = (state == ST_XFER);
  assign accept    = req_valid && ready;
  assign frame_end = xfer && fall_tick && (bit_cnt == BW'(FRAME_W - 1));
  assign gap_end   = (state == ST_GAP) && (gap_cnt == GW'(GAP_CYC - 1));
  assign rb_start  = gap_end && rd_op && !rb_phase;
  assign op_end    = gap_end && !(rd_op && !rb_phase);
  assign rb_frame  = xfer && rb_phase;

  assign addr5       = 5'(req_addr);
  assign first_frame = req_read ? build_frame(DATA_W'(addr5), 5'd0)
                                : build_frame(req_wdata, addr5);
  assign load        = accept || rb_start;
  assign load_val    = accept ? first_frame : '0;
  assign rx_word     = {sr[FRAME_W-2:0], spi_miso};

  assign spi_sel_n = !xfer;
  assign spi_mosi  = xfer && sr[FRAME_W-1];

  fltspi_sclk_gen #(.DIV(DIV)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (xfer),
    .sclk      (spi_sclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  fltspi_shreg #(.W(FRAME_W)) u_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .shift    (xfer && fall_tick),
    .din      (rb_frame && spi_miso),
    .word     (sr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rd_op    <= 1'b0;
      rb_phase <= 1'b0;
      bit_cnt  <= '0;
      gap_cnt  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      rd_data  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_XFER;
            rd_op    <= req_read;
            rb_phase <= 1'b0;
            bit_cnt  <= '0;
          end
        end
        ST_XFER: begin
          if (fall_tick) bit_cnt <= bit_cnt + 1'b1;
          if (frame_end) begin
            state   <= ST_GAP;
            gap_cnt <= '0;
            if (rb_phase) begin
              if (tag_ok(rx_word[7:0])) begin
                rd_data <= rx_word[FRAME_W-1:8];
                err     <= 1'b0;
              end else begin
                rd_data <= '0;
                err     <= 1'b1;
              end
            end
          end
        end
        ST_GAP: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (rb_start) begin
            state    <= ST_XFER;
            rb_phase <= 1'b1;
            bit_cnt  <= '0;
          end else if (op_end) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            if (!rd_op) err <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fltspi_engine_chk.sv
module fltspi_engine_chk #(
  parameter int GAP_CYC = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        ready,
  input logic        done,
  input logic        err,
  input logic [23:0] rd_data,
  input logic        spi_sel_n,
  input logic        spi_sclk,
  input logic        spi_mosi,
  input logic        rb_frame
);

  localparam int GW = $clog2(GAP_CYC + 1);

  logic [GW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hi_cnt <= GW'(GAP_CYC);
    else if (!spi_sel_n)            hi_cnt <= '0;
    else if (hi_cnt < GW'(GAP_CYC)) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r2_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sel_n |-> !spi_sclk);

  a_r3_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_sel_n && $past(!spi_sel_n) && !$fell(spi_sclk)) |-> $stable(spi_mosi));

  a_r4_readback_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_sel_n && rb_frame) |-> !spi_mosi);

  a_r6_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rd_data == '0));

  a_r9_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sel_n) |-> (hi_cnt == GW'(GAP_CYC)));

  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready) |=> (!ready && !spi_sel_n));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

endmodule

bind fltspi_engine fltspi_engine_chk #(.GAP_CYC(GAP_SCLK * DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .ready     (ready),
  .done      (done),
  .err       (err),
  .rd_data   (rd_data),
  .spi_sel_n (spi_sel_n),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .rb_frame  (rb_frame)
);

// File: tb/fltspi_engine_test.sv
module fltspi_engine_test;

  localparam int DIV      = 8;
  localparam int GAP_SCLK = 2;
  localparam int AW       = 5;
  localparam int GAP_CYC  = GAP_SCLK * DIV;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_read = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [23:0]   req_wdata = '0;
  logic          ready, done, err;
  logic [23:0]   rd_data;
  logic          spi_sel_n, spi_sclk, spi_mosi, spi_miso;

  fltspi_engine #(.DIV(DIV), .GAP_SCLK(GAP_SCLK), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
    .err(err), .rd_data(rd_data), .spi_sel_n(spi_sel_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [23:0] dev_regs [32];
  logic [31:0] dev_tx = '0, dev_rx = '0, last_frame = '0;
  logic        rd_pending = 1'b0, miso_dev = 1'b0, noise = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit          frame_open = 0, seen_frame = 0, per_bad = 0, rb_nonzero = 0, bad_id_mode = 0;
  int          dev_cnt = 0, frames = 0;
  time         last_rise = 0, last_cs_rise = 0;

  assign spi_miso = (rd_pending && !spi_sel_n) ? miso_dev : noise;

  always @(negedge clk) begin
    lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    noise <= lfsr[0];
  end

  always @(negedge spi_sel_n) begin
    if (seen_frame)
      check(($time - last_cs_rise) >= GAP_CYC * 10, "R9", "select-high gap (ns)",
            32'($time - last_cs_rise), 32'(GAP_CYC * 10));
    frame_open = 1;
    dev_cnt    = 0;
    dev_rx     = '0;
    per_bad    = 0;
  end

  always @(posedge spi_sclk) begin
    if (!spi_sel_n) begin
      if (dev_cnt > 0 && ($time - last_rise) != DIV * 10) per_bad = 1;
      last_rise = $time;
      dev_rx    = {dev_rx[30:0], spi_mosi};
      if (rd_pending) miso_dev <= dev_tx[31 - dev_cnt];
      dev_cnt++;
    end
  end

  always @(posedge spi_sel_n) begin
    if (frame_open) begin
      frame_open   = 0;
      seen_frame   = 1;
      last_cs_rise = $time;
      frames++;
      check(dev_cnt == 32 && !per_bad, "R2 R8", "rising edges per frame / period ok",
            32'(dev_cnt), 32'd32);
      if (rd_pending) begin
        rd_pending = 1'b0;
        if (dev_rx != '0) rb_nonzero = 1;
      end else begin
        last_frame = dev_rx;
        if (dev_rx[2:0] == 3'b101) begin
          if (dev_rx[7:3] == 5'd0) begin
            rd_pending = 1'b1;
            dev_tx = {dev_regs[dev_rx[12:8]], dev_rx[12:8],
                      bad_id_mode ? 3'b110 : 3'b101};
          end else begin
            dev_regs[dev_rx[7:3]] = dev_rx[31:8];
          end
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic        err;
    logic [23:0] data;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [23:0] shadow [32];
  logic [23:0] exp_rd = '0;
  logic        prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done)
        check(!done, "R11", "done width", 32'(done), 32'd0);
      if (done) begin
        check(ready, "R11", "ready with done", 32'(ready), 32'd1);
        if (sb.size() == 0) begin
          check(0, "R11", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(err == e.err && rd_data == e.data, e.tag, "err/rd_data",
                {7'd0, err, rd_data}, {7'd0, e.err, e.data});
        end
      end
    end
    prev_done <= done;
  end

  task automatic op(input bit rd, input logic [4:0] a, input logic [23:0] wd,
                    input string tag, input bit exp_err, input bit poke);
    int   f0;
    exp_t e;
    while (!ready) @(negedge clk);
    f0 = frames;
    e.tag = tag;
    if (rd) begin
      e.err  = exp_err;
      e.data = exp_err ? 24'd0 : shadow[a];
      exp_rd = e.data;
    end else begin
      e.err  = 1'b0;
      e.data = exp_rd;
      shadow[a] = wd;
    end
    sb.push_back(e);
    req_valid = 1'b1; req_read = rd; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      req_valid = 1'b1; req_read = 1'b0; req_addr = 5'd9; req_wdata = 24'h123456;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(frames - f0 == (rd ? 2 : 1), rd ? "R4" : (poke ? "R10" : "R8"),
          "frames per operation", 32'(frames - f0), rd ? 32'd2 : 32'd1);
    if (rd)
      check(last_frame == {19'd0, a, 8'b0000_0101}, "R4", "pointer frame",
            last_frame, {19'd0, a, 8'b0000_0101});
    else
      check(last_frame == {wd, a, 3'b101}, "R1", "write frame",
            last_frame, {wd, a, 3'b101});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog: actual no completion expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      dev_regs[i] = '0;
      shadow[i]   = '0;
    end
    repeat (3) @(negedge clk);
    check(ready && !done && !err && rd_data == 0, "R11", "reset handshake state",
          {6'd0, ready, done, err, rd_data}, {6'd0, 3'b100, 24'd0});
    check(spi_sel_n && !spi_sclk, "R2 R8", "reset select/clock",
          {30'd0, spi_sel_n, spi_sclk}, 32'd2);
    rst_n = 1'b1;
    @(negedge clk);

    op(0, 5'd1,  24'hA5C3F0, "R1", 0, 0);
    op(0, 5'd31, 24'h000001, "R1", 0, 0);
    op(0, 5'd7,  24'hFFFFFF, "R3", 0, 0);
    op(0, 5'd16, 24'h800000, "R10", 0, 1);
    op(1, 5'd1,  24'h0,      "R5", 0, 0);
    op(1, 5'd31, 24'h0,      "R5", 0, 0);
    op(1, 5'd16, 24'h0,      "R5", 0, 0);
    op(1, 5'd7,  24'h0,      "R5", 0, 0);
    bad_id_mode = 1;
    op(1, 5'd7,  24'h0,      "R6", 1, 0);
    bad_id_mode = 0;
    op(0, 5'd2,  24'h3C3C3C, "R7", 0, 0);
    op(1, 5'd2,  24'h0,      "R5", 0, 0);
    op(0, 5'd3,  24'h5A5A5A, "R7", 0, 0);
    op(1, 5'd9,  24'h0,      "R10", 0, 0);

    check(!rb_nonzero, "R4", "read-back frame output all zero",
          32'(rb_nonzero), 32'd0);
    check(sb.size() == 0, "R11", "pending expectations", 32'(sb.size()), 32'd0);
    finish_run();
  end

endmodule